// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the flow controller of a register-rename pipeline stage. Each cycle it is offered a group of up to `WIDTH` instructions from decode. Each instruction slot carries a valid bit, a serialising flag and a destination-register count. The block decides which slots are renamed this cycle and raises a stall back to decode. When the stage cannot take a group, it parks the unrenamed part in an internal skid FIFO and replays it later. Register mapping happens elsewhere. This block only emits a per-slot rename-enable mask and says whether that mask refers to the live decode group or to the skid head.

The controller has six states. **Idle** (after reset) and **Running** take instructions straight from decode. **Blocked** holds while downstream pressure persists. **Unblocking** replays the skid FIFO head by head. **Squashing** discards work while commit recovers. **BarrierStall** holds a serialising instruction until the reorder buffer drains.

The named transitions are:
- Idle→Running: the first group is handled.
- Running/Idle/Unblocking→Blocked: an external stall, zero adjusted capacity, a physical-register shortage or the width cap leaves instructions unrenamed.
- Any state except Squashing→Squashing: squash or squash-busy is seen.
- Blocked→Unblocking or Running: all pressure is gone; Unblocking is taken if the skid holds groups.
- Unblocking→Running: the skid drains.
- Running/Unblocking→BarrierStall: a serialising instruction is met.
- BarrierStall→Unblocking or Running: the reorder buffer is completely free.
- Squashing→Running: both squash inputs are low.

The per-cycle capacity is the minimum of three values: the free ROB count minus `FB_DELAY` (floored at 0), the free IQ count minus `FB_DELAY` (floored at 0), and `WIDTH`.

Top module: `rn_stall_ctrl`

## Requirements
- R1: While reset is held and right after it, `state_o` is Idle, `stall_dec` is low, `ren_en` is zero and the skid FIFO is empty.
- R2: In Idle, Running or Unblocking, valid slots are renamed in ascending slot order, at most min(adjusted ROB, adjusted IQ, WIDTH) per cycle. Any valid slots beyond that cap are saved to the skid, stall is raised and the next state is Blocked.
- R3: If either adjusted free count is zero, nothing is renamed, stall is raised, a valid decode group is saved to the skid, and the next state is Blocked.
- R4: An execute or commit stall input in Idle, Running or Unblocking renames nothing, raises stall, saves a valid decode group, and moves to Blocked.
- R5: In Blocked, stall is high, nothing is renamed and valid decode groups are saved. The state leaves only when both stall inputs are low and both raw free counts are nonzero: to Unblocking if the skid holds a group, otherwise to Running.
- R6: In Unblocking, slots come from the skid head (`ren_from_skid` high) and stall stays high. A fully renamed head is popped, a partly renamed head keeps only its remaining slots, and the state returns to Running once the last group is popped.
- R7: Before each slot, if free physical registers (less those already used this cycle) are fewer than its destination count, renaming stops at that slot; the rest is saved, stall is raised and the next state is Blocked. A slot with zero destinations always fits.
- R8: A serialising slot stops renaming before itself, raises stall and enters BarrierStall. That state exits when the free ROB count equals `ROB_SIZE`, and the held instruction is then renamed on replay.
- R9: A squash or squash-busy input empties the skid and enters Squashing, where nothing is renamed and stall is low. A new squash keeps it there; Running follows once both inputs are low.
- R10: `state_o` encodes Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4, BarrierStall=5. Slot i of a group uses bit i of valid/serial and bits [i*DST_W +: DST_W] of the destination counts.
- R11: A push into a full skid FIFO is never legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | WIDTH | Per-slot valid bits of the decode group |
| dec_serial | input | WIDTH | Per-slot serialising flags |
| dec_dst | input | WIDTH*DST_W | Per-slot destination-register counts |
| exe_stall | input | 1 | Stall request from execute |
| cmt_stall | input | 1 | Stall request from commit |
| rob_free | input | ROB_CW | Free reorder-buffer entries |
| iq_free | input | IQ_CW | Free issue-queue entries |
| preg_free | input | PREG_CW | Free physical registers |
| sq_flag | input | 1 | Squash from commit |
| sq_busy | input | 1 | Commit squash still in progress |
| stall_dec | output | 1 | Stall back to decode |
| ren_en | output | WIDTH | Slots renamed this cycle |
| ren_from_skid | output | 1 | `ren_en` refers to the skid head rather than decode |
| state_o | output | 3 | Current controller state |

## Verification
On every cycle, the assertions check the following:
- Blocked always stalls and renames nothing.
- Squashing is silent.
- A squash input always leads to Squashing.
- An external stall leads to Blocked.
- BarrierStall holds until the ROB is fully free.
- Renames never exceed either adjusted capacity.
- Unblocking renames only from the skid.
- The FIFO never overflows.

Only the bench scenarios show that saved remainders are replayed with exactly the right slots, in the right order and at the right time. The same applies to three further effects: a squash really discards the parked groups, a passed barrier lets the serialising instruction through, and a group arriving during replay is queued behind the head.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_BLOCK   = 3'd2,
        ST_UNBLK   = 3'd3,
        ST_SQUASH  = 3'd4,
        ST_BARRIER = 3'd5
    } rn_state_e;

endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
    parameter int GW    = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [GW-1:0]                push_data,
    input  logic                         pop,
    input  logic                         wr_head,
    input  logic [GW-1:0]                wr_head_data,
    output logic [GW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [GW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push)    mem[wr_ptr] <= push_data;
            if (wr_head) mem[rd_ptr] <= wr_head_data;
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> !full)
        else $error("skid FIFO overflow");

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || wr_head) |-> !empty)
        else $error("skid FIFO read while empty");

endmodule

// File: rtl/rn_slot_pick.sv
module rn_slot_pick #(
    parameter int W  = 4,
    parameter int DW = 2,
    parameter int PW = 7,
    parameter int LW = 3
) (
    input  logic [W-1:0]    valid,
    input  logic [W-1:0]    serial,
    input  logic [W*DW-1:0] dst,
    input  logic [LW-1:0]   limit,
    input  logic [PW-1:0]   preg_free,
    input  logic            ser_pass,
    output logic [W-1:0]    ren,
    output logic [W-1:0]    left,
    output logic            hit_serial
);
    always_comb begin
        int  cnt;
        int  used;
        logic stop;
        cnt        = 0;
        used       = 0;
        stop       = 1'b0;
        ren        = '0;
        hit_serial = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (valid[i] && !stop) begin
                if (cnt >= int'(limit)) begin
                    stop = 1'b1;
                end else if (serial[i] && !(ser_pass && cnt == 0)) begin
                    stop       = 1'b1;
                    hit_serial = 1'b1;
                end else if (int'(preg_free) - used < int'(dst[i*DW +: DW])) begin
                    stop = 1'b1;
                end else begin
                    ren[i] = 1'b1;
                    cnt    = cnt + 1;
                    used   = used + int'(dst[i*DW +: DW]);
                end
            end
        end
        left = valid & ~ren;
    end

endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
    import rn_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter int DST_W    = 2,
    parameter int ROB_SIZE = 32,
    parameter int IQ_SIZE  = 16,
    parameter int PREG_CW  = 7,
    parameter int FB_DELAY = 1,
    parameter int SKID_DEP = 4,
    parameter int ROB_CW   = $clog2(ROB_SIZE+1),
    parameter int IQ_CW    = $clog2(IQ_SIZE+1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIDTH-1:0]       dec_valid,
    input  logic [WIDTH-1:0]       dec_serial,
    input  logic [WIDTH*DST_W-1:0] dec_dst,
    input  logic                   exe_stall,
    input  logic                   cmt_stall,
    input  logic [ROB_CW-1:0]      rob_free,
    input  logic [IQ_CW-1:0]       iq_free,
    input  logic [PREG_CW-1:0]     preg_free,
    input  logic                   sq_flag,
    input  logic                   sq_busy,
    output logic                   stall_dec,
    output logic [WIDTH-1:0]       ren_en,
    output logic                   ren_from_skid,
    output logic [2:0]             state_o
);
    localparam int GW  = WIDTH * (2 + DST_W);
    localparam int LW  = $clog2(WIDTH+1);
    localparam int SCW = $clog2(SKID_DEP+1);

    rn_state_e st_q, st_d;
    logic      ser_pass_q, ser_set, ser_clr;

    // skid FIFO controls
    logic            f_push, f_pop, f_wr_head, f_flush, f_empty, f_full;
    logic [GW-1:0]   f_push_d, f_wr_head_d, f_head;
    logic [SCW-1:0]  f_count;

    // group views
    logic [GW-1:0]          dec_grp;
    logic                   unblk;
    logic [WIDTH-1:0]       src_valid, src_serial;
    logic [WIDTH*DST_W-1:0] src_dst;
    logic                   squash_any, ext_stall, dec_any;

    // capacity
    logic [ROB_CW-1:0] rob_adj;
    logic [IQ_CW-1:0]  iq_adj;
    logic [LW-1:0]     limit;

    // slot picker results
    logic [WIDTH-1:0] sel_ren, sel_left;
    logic             sel_serial;

    assign dec_grp    = {dec_dst, dec_serial, dec_valid};
    assign unblk      = (st_q == ST_UNBLK);
    assign src_valid  = unblk ? f_head[WIDTH-1:0]       : dec_valid;
    assign src_serial = unblk ? f_head[2*WIDTH-1:WIDTH] : dec_serial;
    assign src_dst    = unblk ? f_head[GW-1:2*WIDTH]    : dec_dst;
    assign squash_any = sq_flag | sq_busy;
    assign ext_stall  = exe_stall | cmt_stall;
    assign dec_any    = |dec_valid;

    assign rob_adj = (rob_free > ROB_CW'(FB_DELAY)) ? rob_free - ROB_CW'(FB_DELAY) : '0;
    assign iq_adj  = (iq_free  > IQ_CW'(FB_DELAY))  ? iq_free  - IQ_CW'(FB_DELAY)  : '0;

    always_comb begin
        int m;
        m = WIDTH;
        if (int'(rob_adj) < m) m = int'(rob_adj);
        if (int'(iq_adj)  < m) m = int'(iq_adj);
        limit = LW'(m);
    end

    rn_skid_fifo #(.GW(GW), .DEPTH(SKID_DEP)) u_skid (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (f_flush),
        .push         (f_push),
        .push_data    (f_push_d),
        .pop          (f_pop),
        .wr_head      (f_wr_head),
        .wr_head_data (f_wr_head_d),
        .head         (f_head),
        .count        (f_count),
        .empty        (f_empty),
        .full         (f_full)
    );

    rn_slot_pick #(.W(WIDTH), .DW(DST_W), .PW(PREG_CW), .LW(LW)) u_pick (
        .valid      (src_valid),
        .serial     (src_serial),
        .dst        (src_dst),
        .limit      (limit),
        .preg_free  (preg_free),
        .ser_pass   (ser_pass_q),
        .ren        (sel_ren),
        .left       (sel_left),
        .hit_serial (sel_serial)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            ser_pass_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ser_clr)      ser_pass_q <= 1'b0;
            else if (ser_set) ser_pass_q <= 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        st_d          = st_q;
        stall_dec     = 1'b0;
        ren_en        = '0;
        ren_from_skid = 1'b0;
        f_push        = 1'b0;
        f_push_d      = dec_grp;
        f_pop         = 1'b0;
        f_wr_head     = 1'b0;
        f_wr_head_d   = f_head;
        f_flush       = 1'b0;
        ser_set       = 1'b0;
        ser_clr       = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (squash_any) begin
                    f_flush = 1'b1;
                    ser_clr = 1'b1;
                    st_d    = ST_SQUASH;
                end else if (ext_stall) begin
                    stall_dec = 1'b1;
                    f_push    = dec_any;
                    st_d      = ST_BLOCK;
                end else if (src_valid == '0) begin
                    stall_dec = unblk;
                end else if (rob_adj == '0 || iq_adj == '0) begin
                    stall_dec = 1'b1;
                    f_push    = dec_any;
                    st_d      = ST_BLOCK;
                end else begin
                    ren_en        = sel_ren;
                    ren_from_skid = unblk;
                    ser_clr       = |sel_ren;
                    if (|sel_left) begin
                        stall_dec = 1'b1;
                        st_d      = sel_serial ? ST_BARRIER : ST_BLOCK;
                        if (unblk) begin
                            f_wr_head   = 1'b1;
                            f_wr_head_d = {src_dst, src_serial, sel_left};
                            f_push      = dec_any;
                        end else begin
                            f_push   = 1'b1;
                            f_push_d = {dec_dst, dec_serial, sel_left};
                        end
                    end else if (unblk) begin
                        stall_dec = 1'b1;
                        f_pop     = 1'b1;
                        f_push    = dec_any;
                        st_d      = (f_count == SCW'(1) && !dec_any) ? ST_RUN : ST_UNBLK;
                    end else begin
                        st_d = ST_RUN;
                    end
                end
            end
            ST_BLOCK: begin
                stall_dec = 1'b1;
                if (squash_any) begin
                    f_flush = 1'b1;
                    ser_clr = 1'b1;
                    st_d    = ST_SQUASH;
                end else begin
                    f_push = dec_any;
                    if (!ext_stall && rob_free != '0 && iq_free != '0)
                        st_d = (f_empty && !dec_any) ? ST_RUN : ST_UNBLK;
                end
            end
            ST_SQUASH: begin
                if (sq_flag)       f_flush = 1'b1;
                else if (!sq_busy) st_d    = ST_RUN;
            end
            ST_BARRIER: begin
                stall_dec = 1'b1;
                if (squash_any) begin
                    f_flush = 1'b1;
                    ser_clr = 1'b1;
                    st_d    = ST_SQUASH;
                end else begin
                    f_push = dec_any;
                    if (rob_free == ROB_CW'(ROB_SIZE)) begin
                        ser_set = 1'b1;
                        st_d    = (f_empty && !dec_any) ? ST_RUN : ST_UNBLK;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign state_o = st_q;

    assert_blocked_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BLOCK) |-> (stall_dec && ren_en == '0))
        else $error("Blocked without stall or with rename");

    assert_squash_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_any |=> (st_q == ST_SQUASH))
        else $error("squash input did not lead to Squashing");

    assert_squash_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SQUASH) |-> (!stall_dec && ren_en == '0))
        else $error("Squashing not silent");

    assert_ext_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_stall && !squash_any && st_q != ST_SQUASH && st_q != ST_BARRIER)
            |=> (st_q == ST_BLOCK))
        else $error("external stall did not block");

    assert_rename_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ren_en) <= int'(rob_adj)) && ($countones(ren_en) <= int'(iq_adj)))
        else $error("rename count above capacity");

    assert_barrier_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BARRIER && !squash_any && rob_free != ROB_CW'(ROB_SIZE))
            |=> (st_q == ST_BARRIER))
        else $error("left BarrierStall before ROB drained");

    assert_skid_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_UNBLK && ren_en != '0) |-> ren_from_skid)
        else $error("Unblocking renamed from decode");

endmodule

// File: tb/rn_stall_ctrl_tb.sv
`timescale 1ns/100ps
module rn_stall_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dec_valid = '0, dec_serial = '0;
    logic [7:0] dec_dst = '0;
    logic       exe_stall = 1'b0, cmt_stall = 1'b0;
    logic [5:0] rob_free = 6'd20;
    logic [4:0] iq_free = 5'd10;
    logic [6:0] preg_free = 7'd50;
    logic       sq_flag = 1'b0, sq_busy = 1'b0;
    logic       stall_dec, ren_from_skid;
    logic [3:0] ren_en;
    logic [2:0] state_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rn_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_serial(dec_serial),
        .dec_dst(dec_dst), .exe_stall(exe_stall), .cmt_stall(cmt_stall),
        .rob_free(rob_free), .iq_free(iq_free), .preg_free(preg_free),
        .sq_flag(sq_flag), .sq_busy(sq_busy), .stall_dec(stall_dec),
        .ren_en(ren_en), .ren_from_skid(ren_from_skid), .state_o(state_o)
    );

    typedef struct packed {
        logic [3:0] v;   logic [3:0] s;   logic [7:0] d;
        logic es;        logic cs;
        logic [5:0] rob; logic [4:0] iq;  logic [6:0] pr;
        logic sf;        logic sb;
        logic [2:0] est; logic estall;    logic [3:0] eren; logic eskid;
    } vec_t;

    localparam int NV = 33;
    // state codes per R10: 0 Idle 1 Run 2 Blocked 3 Unblocking 4 Squashing 5 Barrier
    localparam vec_t TBL [NV] = '{
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd0,1'b0,4'h0,1'b0}, // 0  R2 idle
        '{4'hF,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd0,1'b0,4'hF,1'b0}, // 1  R2 full width
        '{4'h7,4'h0,8'h55,1'b0,1'b0,6'd3 ,5'd10,7'd50,1'b0,1'b0,3'd1,1'b1,4'h3,1'b0}, // 2  R2 rob cap
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 3  R5
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h4,1'b1}, // 4  R6 replay
        '{4'h3,4'h0,8'h55,1'b1,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd1,1'b1,4'h0,1'b0}, // 5  R4
        '{4'h1,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 6  R5 save
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h3,1'b1}, // 7  R6
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h1,1'b1}, // 8  R6
        '{4'h7,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd1 ,1'b0,1'b0,3'd1,1'b1,4'h1,1'b0}, // 9  R7
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 10 R5
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h6,1'b1}, // 11 R6
        '{4'hF,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b1,1'b0,3'd1,1'b0,4'h0,1'b0}, // 12 R9
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b1,3'd4,1'b0,4'h0,1'b0}, // 13 R9
        '{4'hF,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd4,1'b0,4'h0,1'b0}, // 14 R9
        '{4'h3,4'h2,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd1,1'b1,4'h1,1'b0}, // 15 R8
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd5,1'b1,4'h0,1'b0}, // 16 R8
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd32,5'd10,7'd50,1'b0,1'b0,3'd5,1'b1,4'h0,1'b0}, // 17 R8
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h2,1'b1}, // 18 R8
        '{4'h1,4'h0,8'h55,1'b0,1'b0,6'd1 ,5'd10,7'd50,1'b0,1'b0,3'd1,1'b1,4'h0,1'b0}, // 19 R3
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b1,3'd2,1'b1,4'h0,1'b0}, // 20 R9
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd4,1'b0,4'h0,1'b0}, // 21 R9
        '{4'h0,4'h0,8'h55,1'b1,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd1,1'b1,4'h0,1'b0}, // 22 R4
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 23 R5
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd1,1'b0,4'h0,1'b0}, // 24 R9 flushed
        '{4'hF,4'h0,8'h55,1'b0,1'b0,6'd20,5'd3 ,7'd50,1'b0,1'b0,3'd1,1'b1,4'h3,1'b0}, // 25 R2 iq cap
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd0 ,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 26 R5
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd2,1'b1,4'h0,1'b0}, // 27 R5
        '{4'h1,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'hC,1'b1}, // 28 R6
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd3,1'b1,4'h1,1'b1}, // 29 R6
        '{4'h0,4'h0,8'h55,1'b0,1'b0,6'd20,5'd10,7'd50,1'b0,1'b0,3'd1,1'b0,4'h0,1'b0}, // 30 R6
        '{4'h3,4'h0,8'h00,1'b0,1'b0,6'd20,5'd10,7'd0 ,1'b0,1'b0,3'd1,1'b0,4'h3,1'b0}, // 31 R7 zero dst
        '{4'h0,4'h0,8'h00,1'b0,1'b0,6'd20,5'd10,7'd0 ,1'b0,1'b0,3'd1,1'b0,4'h0,1'b0}  // 32 R7
    };
    localparam int REQ [NV] = '{2,2,2,5,6,4,5,6,6,7,5,6,9,9,9,8,8,8,8,3,9,9,4,5,9,2,5,5,6,6,6,7,7};

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t t);
        dec_valid = t.v;  dec_serial = t.s; dec_dst = t.d;
        exe_stall = t.es; cmt_stall = t.cs;
        rob_free  = t.rob; iq_free = t.iq; preg_free = t.pr;
        sq_flag   = t.sf; sq_busy = t.sb;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(1, "reset state", int'(state_o), 0);
        chk(1, "reset stall", int'(stall_dec), 0);
        chk(1, "reset ren", int'(ren_en), 0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(TBL[k]);
            #1;
            chk(REQ[k], $sformatf("step %0d state", k), int'(state_o), int'(TBL[k].est));
            chk(REQ[k], $sformatf("step %0d stall", k), int'(stall_dec), int'(TBL[k].estall));
            chk(REQ[k], $sformatf("step %0d ren", k), int'(ren_en), int'(TBL[k].eren));
            chk(REQ[k], $sformatf("step %0d skid", k), int'(ren_from_skid), int'(TBL[k].eskid));
        end
        // R1: reset mid-run drops Blocked state and parked groups
        @(negedge clk);
        dec_valid = 4'h3; exe_stall = 1'b1;
        @(negedge clk);
        dec_valid = 4'h0; exe_stall = 1'b0;
        chk(1, "blocked before reset", int'(state_o), 2);
        rst_n = 1'b0;
        #1;
        chk(1, "state in reset", int'(state_o), 0);
        chk(1, "stall in reset", int'(stall_dec), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exe_stall = 1'b1;
        @(negedge clk);
        exe_stall = 1'b0;
        chk(1, "blocked after reset", int'(state_o), 2);
        @(negedge clk);
        chk(1, "empty skid after reset gives Running", int'(state_o), 1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL R1 watchdog: actual 0 expected 1");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule